// File: doc/BRIEF.md
# Pin Interrupt Trigger Detector

This block is the interrupt logic for a single general-purpose pin. It watches the already filtered pin level and, according to its control bits, detects a rising edge, a falling edge, either edge, a high level or a low level. A detected event sets a sticky interrupt status flag, and a separate sticky wake flag when wake is enabled. Software clears each flag by writing one to its clear strobe.

Capture and delivery are controlled separately. The enable bit decides whether an event is recorded in the status flag. The mask bit decides whether a recorded status is driven onto the interrupt request line. A pending output, the OR of both flags, tells the summary logic that this pin needs attention.

Top module: `pin_irq_slice`

## Requirements
- R1: After reset, int_status, wake_status, irq_req and pending are all 0. No edge is reported on the first clock after reset is released, whatever the pin level is.
- R2: In edge mode (level_mode = 0) with act_sel = 2'b00, a 1-to-0 change of pin_level between two consecutive clocks sets int_status on that clock. A rising change or a steady level does not set it.
- R3: In edge mode with act_sel = 2'b01, a 0-to-1 change sets int_status. A falling change or a steady level does not set it.
- R4: In edge mode with act_sel = 2'b10, either change sets int_status and a steady level does not. In level mode the code 2'b10 never sets int_status.
- R5: The code act_sel = 2'b11 never sets int_status or wake_status, in either mode.
- R6: In level mode (level_mode = 1), act_sel = 2'b00 sets int_status while pin_level is 0, and act_sel = 2'b01 sets it while pin_level is 1.
- R7: int_status is set only on a clock where irq_en is 1. With irq_en = 0, events leave the flag unchanged.
- R8: irq_req is 1 exactly when int_status is 1 and irq_unmask is 1. irq_unmask does not affect int_status.
- R9: int_status stays set until a clock where clr_status is 1, after which it reads 0. In edge mode, a clear and a new qualifying edge on the same clock leave the flag set.
- R10: In level mode, a clear drops int_status for one clock. If the active level is still present and irq_en is 1, the flag is set again on the following clock.
- R11: With wake_en = 1, a qualifying event sets wake_status, even when irq_en is 0. clr_wake clears wake_status. pending is the OR of int_status and wake_status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_level | input | 1 | Filtered pin level, synchronous to clk |
| level_mode | input | 1 | 1 selects level sensitivity, 0 selects edge sensitivity |
| act_sel | input | 2 | 00 low or falling, 01 high or rising, 10 both edges, 11 none |
| irq_en | input | 1 | Allows events to be recorded in int_status |
| irq_unmask | input | 1 | 1 passes int_status to irq_req |
| wake_en | input | 1 | Allows events to be recorded in wake_status |
| clr_status | input | 1 | Write-one strobe that clears int_status |
| clr_wake | input | 1 | Write-one strobe that clears wake_status |
| int_status | output | 1 | Sticky interrupt status |
| wake_status | output | 1 | Sticky wake status |
| irq_req | output | 1 | Masked interrupt request |
| pending | output | 1 | Flags the pin to the summary logic |

## Verification
The assertions assume that pin_level, the control bits and the clear strobes are synchronous to clk and settle well before each rising edge. They also assume that a clear strobe is a plain level that is sampled on every clock it is high. The bench changes every input only on the falling clock edge and holds it for whole cycles, so each value is seen by exactly the rising edges it spans. Each vector first sets the previous pin level with irq_en low and then enables capture for a single clock, so the status that results comes from one known transition or level.

// File: rtl/pin_irq_slice.sv
module pin_irq_slice (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_level,
  input  logic       level_mode,
  input  logic [1:0] act_sel,
  input  logic       irq_en,
  input  logic       irq_unmask,
  input  logic       wake_en,
  input  logic       clr_status,
  input  logic       clr_wake,
  output logic       int_status,
  output logic       wake_status,
  output logic       irq_req,
  output logic       pending
);

  localparam logic [1:0] SEL_LOW  = 2'b00;
  localparam logic [1:0] SEL_HIGH = 2'b01;
  localparam logic [1:0] SEL_BOTH = 2'b10;

  logic pin_q, primed;
  logic rise, fall, edge_hit, lvl_hit, hit;
  logic int_set, wake_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      primed <= 1'b0;
    end else begin
      pin_q  <= pin_level;
      primed <= 1'b1;
    end
  end

  assign rise = primed &  pin_level & ~pin_q;
  assign fall = primed & ~pin_level &  pin_q;

  always_comb begin
    edge_hit = 1'b0;
    lvl_hit  = 1'b0;
    case (act_sel)
      SEL_LOW:  begin edge_hit = fall;        lvl_hit = ~pin_level; end
      SEL_HIGH: begin edge_hit = rise;        lvl_hit =  pin_level; end
      SEL_BOTH: begin edge_hit = rise | fall; lvl_hit = 1'b0;       end
      default:  begin edge_hit = 1'b0;        lvl_hit = 1'b0;       end
    endcase
  end

  assign hit      = level_mode ? lvl_hit : edge_hit;
  assign int_set  = irq_en  & hit & ~(level_mode & clr_status);
  assign wake_set = wake_en & hit & ~(level_mode & clr_wake);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_status  <= 1'b0;
      wake_status <= 1'b0;
    end else begin
      if (int_set)         int_status <= 1'b1;
      else if (clr_status) int_status <= 1'b0;
      if (wake_set)        wake_status <= 1'b1;
      else if (clr_wake)   wake_status <= 1'b0;
    end
  end

  assign irq_req = int_status & irq_unmask;
  assign pending = int_status | wake_status;

endmodule

// File: rtl/pin_irq_slice_chk.sv
module pin_irq_slice_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       level_mode,
  input logic [1:0] act_sel,
  input logic       irq_en,
  input logic       irq_unmask,
  input logic       wake_en,
  input logic       clr_status,
  input logic       clr_wake,
  input logic       int_status,
  input logic       wake_status,
  input logic       irq_req,
  input logic       pending
);

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_unmask |-> !irq_req);

  assert_pending_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> (!int_status && !wake_status));

  assert_code3_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sel == 2'b11 && !int_status && !clr_status) |=> !int_status);

  assert_enable_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !int_status) |=> !int_status);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_status && !clr_status) |=> int_status);

  assert_level_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && clr_status) |=> !int_status);

  assert_wake_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_en && !wake_status) |=> !wake_status);

endmodule

bind pin_irq_slice pin_irq_slice_chk chk_i (
  .clk(clk), .rst_n(rst_n), .level_mode(level_mode), .act_sel(act_sel),
  .irq_en(irq_en), .irq_unmask(irq_unmask), .wake_en(wake_en),
  .clr_status(clr_status), .clr_wake(clr_wake), .int_status(int_status),
  .wake_status(wake_status), .irq_req(irq_req), .pending(pending)
);

// File: tb/pin_irq_slice_tb_top.sv
module pin_irq_slice_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_level = 1'b0, level_mode = 1'b0, irq_en = 1'b0, irq_unmask = 1'b1;
  logic wake_en = 1'b0, clr_status = 1'b0, clr_wake = 1'b0;
  logic [1:0] act_sel = 2'b00;
  logic int_status, wake_status, irq_req, pending;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_irq_slice dut_i (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .level_mode(level_mode),
    .act_sel(act_sel), .irq_en(irq_en), .irq_unmask(irq_unmask),
    .wake_en(wake_en), .clr_status(clr_status), .clr_wake(clr_wake),
    .int_status(int_status), .wake_status(wake_status),
    .irq_req(irq_req), .pending(pending)
  );

  // {level_mode, act_sel[1:0], prev pin, new pin, expected status}
  localparam logic [5:0] VEC [20] = '{
    6'b0_00_10_1, 6'b0_00_01_0, 6'b0_00_00_0,
    6'b0_01_01_1, 6'b0_01_10_0, 6'b0_01_11_0,
    6'b0_10_01_1, 6'b0_10_10_1, 6'b0_10_11_0, 6'b0_10_00_0,
    6'b0_11_01_0, 6'b0_11_10_0,
    6'b1_00_10_1, 6'b1_00_01_0,
    6'b1_01_01_1, 6'b1_01_10_0,
    6'b1_10_01_0, 6'b1_10_10_0,
    6'b1_11_01_0, 6'b1_11_10_0
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic string req_of(logic lm, logic [1:0] a);
    if (a == 2'b11) return "R5";
    if (lm) return (a == 2'b10) ? "R4" : "R6";
    case (a)
      2'b00: return "R2";
      2'b01: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    // R1: reset with the pin high, rising-edge mode, capture enabled
    pin_level = 1'b1; act_sel = 2'b01; irq_en = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", "int_status in reset", int_status, 1'b0);
    check("R1", "pending in reset", pending, 1'b0);
    check("R1", "irq_req in reset", irq_req, 1'b0);
    rst_n = 1'b1;
    step(); step();
    check("R1", "no edge after reset", int_status, 1'b0);
    irq_en = 1'b0;

    foreach (VEC[k]) begin
      level_mode = VEC[k][5]; act_sel = VEC[k][4:3]; pin_level = VEC[k][2];
      irq_en = 1'b0; clr_status = 1'b1;
      step(); step();
      clr_status = 1'b0;
      step();
      irq_en = 1'b1; pin_level = VEC[k][1];
      step();
      check(req_of(VEC[k][5], VEC[k][4:3]), $sformatf("vector %0d status", k), int_status, VEC[k][0]);
      check("R8", $sformatf("vector %0d request", k), irq_req, VEC[k][0]);
      irq_en = 1'b0; clr_status = 1'b1;
      step();
      clr_status = 1'b0;
    end

    // R8: masked status held, then delivered on unmask
    level_mode = 1'b0; act_sel = 2'b01; irq_unmask = 1'b0; pin_level = 1'b0;
    step();
    irq_en = 1'b1; pin_level = 1'b1;
    step();
    check("R8", "status while masked", int_status, 1'b1);
    check("R8", "request while masked", irq_req, 1'b0);
    irq_unmask = 1'b1;
    #1;
    check("R8", "request after unmask", irq_req, 1'b1);

    // R9: clear together with a new edge keeps the status
    pin_level = 1'b0;
    step();
    pin_level = 1'b1; clr_status = 1'b1;
    step();
    check("R9", "clear with edge", int_status, 1'b1);
    step();
    check("R9", "clear without edge", int_status, 1'b0);
    clr_status = 1'b0;

    // R7: events ignored while disabled
    irq_en = 1'b0; pin_level = 1'b0;
    step();
    pin_level = 1'b1;
    step();
    check("R7", "disabled edge", int_status, 1'b0);
    check("R7", "disabled pending", pending, 1'b0);

    // R10: level mode clear drops one cycle then re-asserts
    level_mode = 1'b1; act_sel = 2'b01; irq_en = 1'b1;
    step();
    check("R10", "level set", int_status, 1'b1);
    clr_status = 1'b1;
    step();
    check("R10", "level cleared", int_status, 1'b0);
    clr_status = 1'b0;
    step();
    check("R10", "level re-asserted", int_status, 1'b1);
    irq_en = 1'b0; pin_level = 1'b0; clr_status = 1'b1;
    step();
    clr_status = 1'b0;

    // R11: wake status independent of interrupt enable
    level_mode = 1'b0; act_sel = 2'b10; wake_en = 1'b1; pin_level = 1'b1;
    step();
    pin_level = 1'b0;
    step();
    check("R11", "wake set", wake_status, 1'b1);
    check("R11", "int untouched", int_status, 1'b0);
    check("R11", "pending from wake", pending, 1'b1);
    check("R11", "no request from wake", irq_req, 1'b0);
    wake_en = 1'b0; clr_wake = 1'b1;
    step();
    clr_wake = 1'b0;
    check("R11", "wake cleared", wake_status, 1'b0);
    check("R11", "pending cleared", pending, 1'b0);

    finish_up();
  end

endmodule